// File: doc/BRIEF.md
# Frame-wise Window Averager

This block smooths a stream of unsigned 17-bit samples that arrive in frames of 128. Each sample carries an implicit bin number, its position within the current frame. The block keeps the eight most recent frames on chip. For every incoming sample it returns the mean of the eight stored values for that bin, one value from each of the last eight frames. The result is a per-bin average across time, not a sliding average along one frame.

Samples are accepted only on cycles where the input valid is high. The bin counter and the frame slot pointer both advance from accepted samples alone. When a frame completes, the slot pointer moves on, so the oldest frame is the next one overwritten. A per-bin running sum is kept beside the history. A new result therefore costs one read, one add and one subtract instead of an eight-way addition. A parameter can select the plain eight-way adder in place of the running sum.

Top module: `frame_window_avg`

## Requirements
- R1: After synchronous reset, out_valid is 0 and out_data is 0, and every stored sample, running sum, bin counter and slot pointer is zero.
- R2: out_valid is high in the cycle after each cycle with in_valid high, and low in the cycle after each cycle with in_valid low.
- R3: The out_data produced for an accepted sample equals the sum of the eight stored values at that sample's bin, with the new sample already replacing the old entry, divided by 8.
- R4: Until eight frames have been accepted since reset, slots that have not been written count as zero in the average.
- R5: The bin counter runs 0 to 127 and wraps to 0. On each wrap the slot pointer advances by one modulo 8, so the ninth frame overwrites the first.
- R6: Cycles with in_valid low change neither the stored samples nor the running sums, the bin counter or the slot pointer.
- R7: Eight full-scale samples of 0x1FFFF at one bin produce exactly 0x1FFFF. The internal sum does not overflow.
- R8: Division by 8 truncates toward zero. A bin whose eight values sum to 15 yields 1.
- R9: A reset asserted partway through a frame restarts at bin 0, slot 0, with an empty history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | 17 | Unsigned input sample |
| out_valid | output | 1 | Average present this cycle |
| out_data | output | 17 | Unsigned per-bin average |

## Verification
The first frame after reset carries a bin-dependent ramp. Its results must equal each sample shifted right by three, which shows that unwritten slots contribute zero. Eight further frames with frame-dependent patterns follow. The last of them wraps the slot pointer onto the first frame, which separates a correct oldest-frame eviction from a stale or double-counted entry. Idle gaps in mid-frame, all-ones frames, a sum of 15 at every bin and a mid-frame reset separate, in turn: counters that move without valid data, overflow of the sum, rounding instead of truncation, and state that survives reset.

// File: rtl/wavg_pkg.sv
package wavg_pkg;

   // Default geometry of the averager
   localparam int unsigned WAVG_DATA_W    = 17;
   localparam int unsigned WAVG_FRAME_LEN = 128;
   localparam int unsigned WAVG_NFRAMES   = 8;

   // How the per-bin total is formed
   typedef enum logic {
      SUM_RUNNING = 1'b0,   // keep a running total per bin
      SUM_DIRECT  = 1'b1    // add all slots of the bin every sample
   } sum_mode_e;

endpackage

// File: rtl/wavg_index_ctrl.sv
module wavg_index_ctrl #(
   parameter int unsigned FRAME_LEN = 128,
   parameter int unsigned NFRAMES   = 8,
   localparam int unsigned POS_W    = $clog2(FRAME_LEN),
   localparam int unsigned SLOT_W   = $clog2(NFRAMES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [POS_W-1:0]  pos,
   output logic [SLOT_W-1:0] slot
);

   localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_LEN - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NFRAMES - 1);

   logic [POS_W-1:0]  pos_q;
   logic [SLOT_W-1:0] slot_q;
   logic              frame_end;

   assign frame_end = (pos_q == POS_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         slot_q <= '0;
      end else if (step) begin
         pos_q <= frame_end ? '0 : pos_q + POS_W'(1);
         if (frame_end)
            slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
      end
   end

   assign pos  = pos_q;
   assign slot = slot_q;

   // R5: bin wraps and the slot moves on at the end of a frame
   p_pos_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (step && pos_q == POS_LAST) |=>
         (pos_q == '0) &&
         (slot_q == (($past(slot_q) == SLOT_LAST) ? '0 : $past(slot_q) + SLOT_W'(1))));

   // R6: no accepted sample, no movement
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(pos_q) && $stable(slot_q));

endmodule

// File: rtl/wavg_history.sv
module wavg_history #(
   parameter int unsigned DATA_W    = 17,
   parameter int unsigned FRAME_LEN = 128,
   parameter int unsigned NFRAMES   = 8,
   localparam int unsigned POS_W    = $clog2(FRAME_LEN),
   localparam int unsigned SLOT_W   = $clog2(NFRAMES)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           we,
   input  logic [POS_W-1:0]               pos,
   input  logic [SLOT_W-1:0]              slot,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NFRAMES-1:0][DATA_W-1:0] col
);

   logic [DATA_W-1:0] mem [NFRAMES][FRAME_LEN];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int f = 0; f < NFRAMES; f++)
            for (int b = 0; b < FRAME_LEN; b++)
               mem[f][b] <= '0;
      end else if (we) begin
         mem[slot][pos] <= wdata;
      end
   end

   // All frames' values at the current bin
   always_comb begin
      for (int f = 0; f < NFRAMES; f++)
         col[f] = mem[f][pos];
   end

   // R6: an idle cycle leaves the addressed entry untouched
   p_hist_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!we && $stable(pos)) |=> $stable(col));

endmodule

// File: rtl/wavg_sum_bank.sv
module wavg_sum_bank
   import wavg_pkg::*;
#(
   parameter int unsigned DATA_W    = 17,
   parameter int unsigned FRAME_LEN = 128,
   parameter int unsigned NFRAMES   = 8,
   parameter sum_mode_e   MODE      = SUM_RUNNING,
   localparam int unsigned POS_W    = $clog2(FRAME_LEN),
   localparam int unsigned SLOT_W   = $clog2(NFRAMES),
   localparam int unsigned SUM_W    = DATA_W + SLOT_W
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           we,
   input  logic [POS_W-1:0]               pos,
   input  logic [SLOT_W-1:0]              slot,
   input  logic [DATA_W-1:0]              din,
   input  logic [NFRAMES-1:0][DATA_W-1:0] col,
   output logic [SUM_W-1:0]               sum_next
);

   logic [DATA_W-1:0] old_val;
   assign old_val = col[slot];

   generate
      if (MODE == SUM_RUNNING) begin : g_running
         logic [SUM_W-1:0] sums [FRAME_LEN];
         logic [SUM_W-1:0] cur;

         assign cur      = sums[pos];
         assign sum_next = cur + {{SLOT_W{1'b0}}, din} - {{SLOT_W{1'b0}}, old_val};

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int b = 0; b < FRAME_LEN; b++)
                  sums[b] <= '0;
            end else if (we) begin
               sums[pos] <= sum_next;
            end
         end

         // R3: the stored total always contains the value about to leave
         p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
            we |-> (cur >= {{SLOT_W{1'b0}}, old_val}));
      end else begin : g_direct
         always_comb begin
            sum_next = {{SLOT_W{1'b0}}, din};
            for (int f = 0; f < NFRAMES; f++)
               if (SLOT_W'(f) != slot)
                  sum_next = sum_next + {{SLOT_W{1'b0}}, col[f]};
         end
      end
   endgenerate

endmodule

// File: rtl/frame_window_avg.sv
module frame_window_avg
   import wavg_pkg::*;
#(
   parameter int unsigned DATA_W    = WAVG_DATA_W,
   parameter int unsigned FRAME_LEN = WAVG_FRAME_LEN,
   parameter int unsigned NFRAMES   = WAVG_NFRAMES,
   parameter sum_mode_e   MODE      = SUM_RUNNING
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [16:0]       in_data,
   output logic              out_valid,
   output logic [16:0]       out_data
);

   localparam int unsigned POS_W  = $clog2(FRAME_LEN);
   localparam int unsigned SLOT_W = $clog2(NFRAMES);
   localparam int unsigned SUM_W  = DATA_W + SLOT_W;

   generate
      if (DATA_W != 17)
         $error("port width is fixed at 17 bits");
      if (FRAME_LEN < 2 || FRAME_LEN != (1 << POS_W))
         $error("FRAME_LEN must be a power of two, at least 2");
      if (NFRAMES < 2 || NFRAMES != (1 << SLOT_W))
         $error("NFRAMES must be a power of two so the mean is a shift");
   endgenerate

   logic [POS_W-1:0]               pos;
   logic [SLOT_W-1:0]              slot;
   logic [NFRAMES-1:0][DATA_W-1:0] col;
   logic [SUM_W-1:0]               sum_next;

   wavg_index_ctrl #(
      .FRAME_LEN (FRAME_LEN),
      .NFRAMES   (NFRAMES)
   ) u_idx (
      .clk  (clk),
      .rst  (rst),
      .step (in_valid),
      .pos  (pos),
      .slot (slot)
   );

   wavg_history #(
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN),
      .NFRAMES   (NFRAMES)
   ) u_hist (
      .clk   (clk),
      .rst   (rst),
      .we    (in_valid),
      .pos   (pos),
      .slot  (slot),
      .wdata (in_data),
      .col   (col)
   );

   wavg_sum_bank #(
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN),
      .NFRAMES   (NFRAMES),
      .MODE      (MODE)
   ) u_sum (
      .clk      (clk),
      .rst      (rst),
      .we       (in_valid),
      .pos      (pos),
      .slot     (slot),
      .din      (in_data),
      .col      (col),
      .sum_next (sum_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= sum_next[SUM_W-1:SLOT_W];
      end
   end

   // R2: one result per accepted sample, one cycle later
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

endmodule

// File: tb/sim_frame_window_avg.sv
`timescale 1ns/1ps
module sim_frame_window_avg;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [16:0] in_data;
   logic        out_valid;
   logic [16:0] out_data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // reference history, built from the requirements
   int mdl [8][128];
   int mpos;
   int mslot;

   always #4 clk = ~clk;   // 125 MHz

   frame_window_avg u0 (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (bin %0d slot %0d)",
                  req, act, exp, mpos, mslot);
      end
   endtask

   task automatic model_clear();
      for (int f = 0; f < 8; f++)
         for (int b = 0; b < 128; b++)
            mdl[f][b] = 0;
      mpos  = 0;
      mslot = 0;
   endtask

   // drive one sample at a falling edge, check its result one cycle later
   task automatic send(input int x, input string req, output int got);
      int s;
      mdl[mslot][mpos] = x;
      s = 0;
      for (int f = 0; f < 8; f++) s += mdl[f][mpos];
      in_valid = 1'b1;
      in_data  = 17'(x);
      @(negedge clk);
      check({req, " valid"}, int'(out_valid), 1);   // R2
      check(req, int'(out_data), s >> 3);           // R3
      got = int'(out_data);
      if (mpos == 127) begin
         mpos  = 0;
         mslot = (mslot + 1) % 8;
      end else begin
         mpos++;
      end
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      in_data  = 17'h15A5A;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         check("R2 idle valid", int'(out_valid), 0);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      in_data  = '0;
      rst      = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 out_data", int'(out_data), 0);
   endtask

   // first frame: empty slots count as zero
   task automatic t_first_frame();
      int got;
      for (int b = 0; b < 128; b++) begin
         send((b * 977 + 5) & 17'h1FFFF, "R4 first frame", got);
         check("R4 shift of sample", got, ((b * 977 + 5) & 17'h1FFFF) >> 3);
      end
   endtask

   // idle gaps in mid-frame change nothing
   task automatic t_idle_gap();
      int got;
      for (int b = 0; b < 128; b++) begin
         send((b * 31 + 1000) & 17'h1FFFF, "R6 frame with gaps", got);
         if (b == 40 || b == 90) idle(5);
      end
   endtask

   // fill the rest of the window and wrap onto the oldest frame
   task automatic t_fill_and_wrap();
      int got;
      for (int f = 2; f < 9; f++)
         for (int b = 0; b < 128; b++)
            send((f * 12345 + b * (f + 3)) & 17'h1FFFF, "R5 R3 rotation", got);
   endtask

   task automatic t_full_scale();
      int got;
      do_reset();
      for (int f = 0; f < 8; f++)
         for (int b = 0; b < 128; b++) begin
            send(17'h1FFFF, "R7 full scale", got);
            if (f == 7) check("R7 exact max", got, 17'h1FFFF);
         end
   endtask

   task automatic t_truncate();
      int got;
      do_reset();
      for (int b = 0; b < 128; b++) begin
         send(15, "R8 truncate", got);
         check("R8 15/8 gives 1", got, 1);
      end
   endtask

   task automatic t_midreset();
      int got;
      for (int b = 0; b < 50; b++) send(b + 7000, "R9 before reset", got);
      do_reset();
      check("R9 out_valid after reset", int'(out_valid), 0);
      for (int b = 0; b < 128; b++) begin
         send(b * 64 + 3, "R9 after reset", got);
         check("R9 empty history", got, (b * 64 + 3) >> 3);
      end
   endtask

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      in_data  = '0;
      model_clear();
      @(negedge clk);
      t_reset();
      t_first_frame();
      t_idle_gap();
      t_fill_and_wrap();
      idle(2);
      t_full_scale();
      t_truncate();
      t_midreset();
      idle(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule